// File: doc/BRIEF.md
# SHA-256 Iterative Compression Core

This block computes the SHA-256 compression function over already-padded 512-bit message blocks. It performs one round per clock. A host shifts sixteen 32-bit message words into the core, most significant word of the block first, while `startIn` is high. It then pulses `goIn` to hash the block. The core loads its eight working registers from the chaining value in one cycle and runs 64 rounds. Each round draws its message word from a sixteen-entry sliding schedule window and its round constant from an internal table. The working values are then folded back into the chaining value through only two 32-bit adders, two words per cycle over four cycles.

A pulse on `newMsgIn` while the core is idle starts a fresh message by reloading the standard initial hash words. Without that pulse, the next block continues from the chaining value left by the previous block, so multi-block messages are hashed by repeating the load-and-go sequence. The 256-bit result is always visible on `digestOut`, and `doneOut` marks the cycle in which a freshly updated value is ready. Message padding is the host's job.

Top module: `sha256_iter_core`

## Requirements
- R1: After reset `doneOut` is low and `digestOut` equals the standard SHA-256 initial hash words, first word (6a09e667) in bits 255:224.
- R2: A `newMsgIn` pulse sampled while idle reloads the initial hash words; `digestOut` shows them from the following cycle.
- R3: While idle, each rising edge with `startIn` high shifts `wordIn` into the schedule window; after sixteen such edges the first word supplied is message word W0, and each word is four message bytes with the earliest byte in bits 31:24.
- R4: A `goIn` sampled while idle leads to `doneOut` rising exactly 69 clock edges later: 1 load cycle, 64 round cycles and 4 chaining-update cycles.
- R5: `doneOut` is high for exactly one cycle per block.
- R6: After one block with a fresh message, `digestOut` equals the SHA-256 digest of that block as H0..H7 concatenated, H0 most significant.
- R7: Without a `newMsgIn` pulse, a block is compressed starting from the chaining value left by the previous block, so a two-block message yields its standard digest.
- R8: While a block is being processed, `startIn`, `goIn` and `newMsgIn` have no effect on the result.
- R9: Shifting words in while idle does not change `digestOut`; the digest changes only on a chaining update or an initial-value reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Word strobe: shift `wordIn` into the schedule window (idle only) |
| newMsgIn | input | 1 | Reload the initial hash words (idle only) |
| wordIn | input | 32 | Message word, big-endian byte order |
| goIn | input | 1 | Start compressing the loaded block (idle only) |
| digestOut | output | 256 | Chaining value / digest, H0 in bits 255:224 |
| doneOut | output | 1 | One-cycle pulse when the block's update is complete |

## Verification
The bench builds the core with the package defaults: 64 rounds, a sixteen-word window and two adder lanes, giving a four-cycle update. These defaults bring the published digests of the empty message, "abc" and the 56-byte two-block message within reach, so a single wrong constant, rotation or adder lane shows up as a digest mismatch. The fixed 69-edge latency and the one-cycle done pulse are measured directly. Noise is injected on the strobes during both the round phase and the update phase to show that the core ignores it while busy.

// File: rtl/sha256_iter_pkg.sv
package sha256_iter_pkg;

  localparam int WORD_W      = 32;
  localparam int HASH_WORDS  = 8;
  localparam int WIN_DEPTH   = 16;
  localparam int ROUND_NUM   = 64;
  localparam int ADDER_LANES = 2;
  localparam int UPD_STEPS   = HASH_WORDS / ADDER_LANES;
  localparam int ROUND_IDX_W = $clog2(ROUND_NUM);
  localparam int UPD_IDX_W   = (UPD_STEPS > 1) ? $clog2(UPD_STEPS) : 1;
  localparam int HW_IDX_W    = $clog2(HASH_WORDS);
  localparam int DIGEST_W    = WORD_W * HASH_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                   loadIv;
    logic                   shiftIn;
    logic                   loadWork;
    logic                   doRound;
    logic [ROUND_IDX_W-1:0] roundIdx;
    logic                   updEn;
    logic [UPD_IDX_W-1:0]   updIdx;
  } ctrl_t;

  localparam word_t ROUND_K [ROUND_NUM] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t INIT_H [HASH_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSigma0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSigma1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smallSigma0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallSigma1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t chooseFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majorityFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic logic [DIGEST_W-1:0] initDigest();
    logic [DIGEST_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < HASH_WORDS; k++) begin
      acc[DIGEST_W-1-k*WORD_W -: WORD_W] = INIT_H[k];
    end
    return acc;
  endfunction

endpackage

// File: rtl/sha256_iter_ctrl.sv
module sha256_iter_ctrl
  import sha256_iter_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startIn,
  input  logic  newMsgIn,
  input  logic  goIn,
  output ctrl_t ctl,
  output logic  doneOut
);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_ROUND,
    PH_UPDATE
  } phase_t;

  localparam logic [ROUND_IDX_W-1:0] ROUND_LAST = ROUND_IDX_W'(ROUND_NUM - 1);
  localparam logic [ROUND_IDX_W-1:0] UPD_LAST   = ROUND_IDX_W'(UPD_STEPS - 1);

  phase_t                 phaseQ;
  logic [ROUND_IDX_W-1:0] cntQ;
  logic                   doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (phaseQ)
        PH_IDLE: begin
          if (goIn) phaseQ <= PH_LOAD;
        end
        PH_LOAD: begin
          phaseQ <= PH_ROUND;
          cntQ   <= '0;
        end
        PH_ROUND: begin
          if (cntQ == ROUND_LAST) begin
            cntQ   <= '0;
            phaseQ <= PH_UPDATE;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        PH_UPDATE: begin
          if (cntQ == UPD_LAST) begin
            cntQ   <= '0;
            phaseQ <= PH_IDLE;
            doneQ  <= 1'b1;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.loadIv   = (phaseQ == PH_IDLE) && newMsgIn;
    ctl.shiftIn  = (phaseQ == PH_IDLE) && startIn;
    ctl.loadWork = (phaseQ == PH_LOAD);
    ctl.doRound  = (phaseQ == PH_ROUND);
    ctl.roundIdx = cntQ;
    ctl.updEn    = (phaseQ == PH_UPDATE);
    ctl.updIdx   = cntQ[UPD_IDX_W-1:0];
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/sha256_iter_window.sv
module sha256_iter_window
  import sha256_iter_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  shiftEn,
  input  logic  useSched,
  input  word_t wordIn,
  output word_t headWord
);

  word_t winQ [WIN_DEPTH];
  word_t schedWord;
  word_t feedWord;

  // new word for index j+16 from taps j+14, j+9, j+1, j
  assign schedWord = smallSigma1(winQ[WIN_DEPTH-2]) + winQ[WIN_DEPTH-7]
                   + smallSigma0(winQ[1]) + winQ[0];
  assign feedWord  = useSched ? schedWord : wordIn;
  assign headWord  = winQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WIN_DEPTH; i++) winQ[i] <= '0;
    end else if (shiftEn) begin
      for (int i = 0; i < WIN_DEPTH - 1; i++) winQ[i] <= winQ[i+1];
      winQ[WIN_DEPTH-1] <= feedWord;
    end
  end

endmodule

// File: rtl/sha256_iter_datapath.sv
module sha256_iter_datapath
  import sha256_iter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctl,
  input  word_t               wordIn,
  output logic [DIGEST_W-1:0] digestOut
);

  word_t hashQ [HASH_WORDS];
  word_t workQ [HASH_WORDS];
  word_t laneSum [ADDER_LANES];
  word_t roundWord;
  word_t t1;
  word_t t2;

  sha256_iter_window u_win (
    .clk      (clk),
    .rstN     (rstN),
    .shiftEn  (ctl.shiftIn | ctl.doRound),
    .useSched (ctl.doRound),
    .wordIn   (wordIn),
    .headWord (roundWord)
  );

  assign t1 = workQ[7] + bigSigma1(workQ[4]) + chooseFn(workQ[4], workQ[5], workQ[6])
            + ROUND_K[ctl.roundIdx] + roundWord;
  assign t2 = bigSigma0(workQ[0]) + majorityFn(workQ[0], workQ[1], workQ[2]);

  // shared chaining adders, one per lane
  for (genvar l = 0; l < ADDER_LANES; l++) begin : g_lane
    logic [HW_IDX_W-1:0] laneIdx;
    assign laneIdx    = HW_IDX_W'(int'(ctl.updIdx) * ADDER_LANES + l);
    assign laneSum[l] = hashQ[laneIdx] + workQ[laneIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HASH_WORDS; k++) hashQ[k] <= INIT_H[k];
    end else if (ctl.loadIv) begin
      for (int k = 0; k < HASH_WORDS; k++) hashQ[k] <= INIT_H[k];
    end else if (ctl.updEn) begin
      for (int k = 0; k < HASH_WORDS; k++) begin
        if (ctl.updIdx == UPD_IDX_W'(k / ADDER_LANES)) hashQ[k] <= laneSum[k % ADDER_LANES];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HASH_WORDS; k++) workQ[k] <= '0;
    end else if (ctl.loadWork) begin
      for (int k = 0; k < HASH_WORDS; k++) workQ[k] <= hashQ[k];
    end else if (ctl.doRound) begin
      workQ[0] <= t1 + t2;
      workQ[1] <= workQ[0];
      workQ[2] <= workQ[1];
      workQ[3] <= workQ[2];
      workQ[4] <= workQ[3] + t1;
      workQ[5] <= workQ[4];
      workQ[6] <= workQ[5];
      workQ[7] <= workQ[6];
    end
  end

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_pack
    assign digestOut[DIGEST_W-1-k*WORD_W -: WORD_W] = hashQ[k];
  end

endmodule

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
  import sha256_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         newMsgIn,
  input  logic [31:0]  wordIn,
  input  logic         goIn,
  output logic [255:0] digestOut,
  output logic         doneOut
);

  ctrl_t ctlBus;

  sha256_iter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .newMsgIn (newMsgIn),
    .goIn     (goIn),
    .ctl      (ctlBus),
    .doneOut  (doneOut)
  );

  sha256_iter_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .wordIn    (wordIn),
    .digestOut (digestOut)
  );

endmodule

// File: rtl/sha256_iter_chk.sv
module sha256_iter_chk
  import sha256_iter_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                goIn,
  input logic                doneOut,
  input logic [DIGEST_W-1:0] digestOut,
  input ctrl_t               ctl
);

  localparam logic [DIGEST_W-1:0] IV_CAT = initDigest();

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R5

  AST_DONE_AFTER_LAST_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> ($past(ctl.updEn) && ($past(ctl.updIdx) == UPD_IDX_W'(UPD_STEPS - 1)))); // R4

  AST_LOAD_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWork |-> $past(goIn)); // R4

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftIn, ctl.loadWork, ctl.doRound, ctl.updEn})); // R8

  AST_IV_ON_NEWMSG: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.loadIv) |-> (digestOut == IV_CAT)); // R2

  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.updEn) && !$past(ctl.loadIv)) |-> $stable(digestOut)); // R9

endmodule

bind sha256_iter_core sha256_iter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .goIn      (goIn),
  .doneOut   (doneOut),
  .digestOut (digestOut),
  .ctl       (ctlBus)
);

// File: tb/sha256_iter_core_tb.sv
`timescale 1ns/1ps
module sha256_iter_core_tb;

  localparam logic [255:0] IV_DIGEST  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] EMPTY_DIG  = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] ABC_DIG    = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] TWOBLK_DIG = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
  localparam int EXP_LATENCY = 1 + 64 + 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic         newMsgIn = 1'b0;
  logic [31:0]  wordIn = '0;
  logic         goIn = 1'b0;
  logic [255:0] digestOut;
  logic         doneOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sha256_iter_core u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .newMsgIn  (newMsgIn),
    .wordIn    (wordIn),
    .goIn      (goIn),
    .digestOut (digestOut),
    .doneOut   (doneOut)
  );

  task automatic checkVal(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseNewMsg();
    @(negedge clk) newMsgIn = 1'b1;
    @(negedge clk) newMsgIn = 1'b0;
  endtask

  task automatic loadBlock(input logic [31:0] blk [16]);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      startIn = 1'b1;
      wordIn  = blk[i];
    end
    @(negedge clk);
    startIn = 1'b0;
    wordIn  = '0;
  endtask

  // runs one block; noisy drives strobes while busy; checks latency and pulse
  task automatic runBlock(input string req, input bit noisy);
    int n;
    @(negedge clk) goIn = 1'b1;
    @(negedge clk) goIn = 1'b0;
    n = 0;
    while (!doneOut && n < 200) begin
      if (noisy && ((n >= 3 && n <= 8) || (n >= 66 && n <= 68))) begin
        startIn = 1'b1; goIn = 1'b1; newMsgIn = 1'b1; wordIn = 32'hdeadbeef;
      end else begin
        startIn = 1'b0; goIn = 1'b0; newMsgIn = 1'b0; wordIn = '0;
      end
      @(negedge clk);
      n++;
    end
    startIn = 1'b0; goIn = 1'b0; newMsgIn = 1'b0; wordIn = '0;
    checkVal({req, " R4 latency"}, 256'(n), 256'(EXP_LATENCY));
    @(negedge clk);
    checkVal({req, " R5 done pulse width"}, 256'(doneOut), 256'(0));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 done low after reset", 256'(doneOut), 256'(0));
    checkVal("R1 digest is IV after reset", digestOut, IV_DIGEST);
  endtask

  task automatic testEmpty();
    logic [31:0] blk [16];
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h80000000;
    pulseNewMsg();
    loadBlock(blk);
    runBlock("empty", 1'b0);
    checkVal("R6 empty message digest", digestOut, EMPTY_DIG);
  endtask

  task automatic testAbc();
    logic [31:0] blk [16];
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0]  = 32'h61626380;
    blk[15] = 32'h00000018;
    pulseNewMsg();
    checkVal("R2 IV reload before abc", digestOut, IV_DIGEST);
    loadBlock(blk);
    runBlock("abc", 1'b0);
    checkVal("R6 R3 abc digest", digestOut, ABC_DIG);
  endtask

  task automatic testIdleLoad();
    logic [31:0] blk [16];
    for (int i = 0; i < 16; i++) blk[i] = 32'h13579bdf ^ 32'(i * 32'h01010101);
    loadBlock(blk);
    repeat (2) @(negedge clk);
    checkVal("R9 digest held while loading words", digestOut, ABC_DIG);
  endtask

  task automatic testTwoBlock();
    logic [31:0] blk [16];
    for (int i = 0; i < 14; i++) begin
      blk[i] = {8'(8'h61 + i), 8'(8'h62 + i), 8'(8'h63 + i), 8'(8'h64 + i)};
    end
    blk[14] = 32'h80000000;
    blk[15] = 32'h0;
    pulseNewMsg();
    loadBlock(blk);
    runBlock("two-block first", 1'b0);
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[15] = 32'h000001c0;
    loadBlock(blk);
    runBlock("two-block second", 1'b0);
    checkVal("R7 chained two-block digest", digestOut, TWOBLK_DIG);
  endtask

  task automatic testBusyNoise();
    logic [31:0] blk [16];
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0]  = 32'h61626380;
    blk[15] = 32'h00000018;
    pulseNewMsg();
    loadBlock(blk);
    runBlock("noisy abc", 1'b1);
    checkVal("R8 strobes ignored while busy", digestOut, ABC_DIG);
  endtask

  task automatic testReload();
    pulseNewMsg();
    checkVal("R2 new message reloads IV", digestOut, IV_DIGEST);
    checkVal("R5 no done after reload", 256'(doneOut), 256'(0));
  endtask

  initial begin
    testReset();
    testEmpty();
    testAbc();
    testIdleLoad();
    testTwoBlock();
    testBusyNoise();
    testReload();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule